// File: doc/BRIEF.md
# Prefixed Shift, Rotate and Bit Unit

This combinational unit carries out the second byte of a prefixed bit-manipulation instruction on a single 8-bit operand. It takes the instruction byte, the operand and the current flag byte. It returns four things: the new operand value, a write-enable for that value, the updated flag byte, and the 3-bit register selector taken from the instruction byte.

The instruction byte has three fields. The top two bits pick one of four groups: shift/rotate, bit test, bit clear and bit set. The middle three bits give either the sub-operation or the bit index. The low three bits name the register, and this unit only passes them through.

The caller owns the register file, memory operands and timing. It places the unit between an operand read and a write-back, and it writes back only when the write-enable is high.

Top module: `pfx_bitunit`

## Requirements
- R1: Instruction bits 7:6 select the group (00 shift/rotate, 01 bit test, 10 bit clear, 11 bit set), bits 5:3 give the sub-operation or bit index, and `dst_sel` always equals bits 2:0.
- R2: Sub-operation 000 rotates left with old bit 7 going to both C and bit 0; 001 rotates right with old bit 0 going to both C and bit 7.
- R3: Sub-operation 010 rotates left through carry (bit 0 takes old C, C takes old bit 7); 011 rotates right through carry (bit 7 takes old C, C takes old bit 0).
- R4: The four rotate sub-operations (000 to 011) clear Z, N and H whatever the result.
- R5: Sub-operations 100 (left shift, bit 0 gets 0), 101 (right shift, bit 7 kept) and 111 (right shift, bit 7 gets 0) put the bit shifted out into C, clear N and H, and set Z exactly when the result is zero.
- R6: Sub-operation 110 exchanges the two nibbles, clears C, N and H, and sets Z exactly when the result is zero.
- R7: The bit-test group sets Z to the inverse of operand bit [5:3], sets H, clears N, keeps C, holds write-enable low and passes the operand through unchanged.
- R8: The bit-set and bit-clear groups force operand bit [5:3] to 1 or 0, leave all other bits and the whole flag byte unchanged, and raise write-enable.
- R9: Flag layout is Z=bit 7, N=bit 6, H=bit 5, C=bit 4. Flag bits 3:0 pass through unchanged for every instruction, and write-enable is high for every group except bit test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 8 | Second instruction byte |
| opnd_i | input | 8 | Operand value |
| flags_i | input | 8 | Current flag byte |
| result_o | output | 8 | New operand value |
| wr_en_o | output | 1 | Result should be written back |
| flags_o | output | 8 | Updated flag byte |
| dst_sel_o | output | 3 | Register selector from the instruction |

## Verification
The bench sends every instruction byte through the unit, with operands that hold edge patterns and with the carry both clear and set. A unit that mixed up plain and through-carry rotation would show the wrong value in bit 0 or bit 7 whenever carry differs from the bit rotated out. A rotate that set Z on a zero result is caught by rotating 0x01 right through a clear carry. A bit test with non-inverted Z, or one that wrote the operand back, is caught on a set bit and on a clear bit. Two further faults are caught at the operand boundary 0x80: an arithmetic right shift that dropped the sign bit, and a swap that left C alone.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  localparam int W      = 8;
  localparam int HALF   = W / 2;
  localparam int IDX_W  = $clog2(W);
  localparam int FZ     = 7;
  localparam int FN     = 6;
  localparam int FH     = 5;
  localparam int FC     = 4;

  typedef enum logic [1:0] {
    GRP_SHROT = 2'b00,
    GRP_TEST  = 2'b01,
    GRP_CLR   = 2'b10,
    GRP_SET   = 2'b11
  } grp_e;

  typedef struct packed {
    logic [W-1:0] val;
    logic         cout;
    logic         z_allowed;
  } rs_t;

  // Shift/rotate arithmetic, one case per sub-operation code.
  function automatic rs_t rs_eval(input logic [2:0] sub, input logic [W-1:0] d,
                                  input logic cin);
    rs_t r;
    r.z_allowed = 1'b1;
    case (sub)
      3'd0: begin r.val = {d[W-2:0], d[W-1]};     r.cout = d[W-1]; r.z_allowed = 1'b0; end
      3'd1: begin r.val = {d[0], d[W-1:1]};       r.cout = d[0];   r.z_allowed = 1'b0; end
      3'd2: begin r.val = {d[W-2:0], cin};        r.cout = d[W-1]; r.z_allowed = 1'b0; end
      3'd3: begin r.val = {cin, d[W-1:1]};        r.cout = d[0];   r.z_allowed = 1'b0; end
      3'd4: begin r.val = {d[W-2:0], 1'b0};       r.cout = d[W-1]; end
      3'd5: begin r.val = {d[W-1], d[W-1:1]};     r.cout = d[0];   end
      3'd6: begin r.val = {d[HALF-1:0], d[W-1:HALF]}; r.cout = 1'b0; end
      default: begin r.val = {1'b0, d[W-1:1]};    r.cout = d[0];   end
    endcase
    return r;
  endfunction

  function automatic logic [W-1:0] bit_mask(input logic [IDX_W-1:0] idx);
    logic [W-1:0] m;
    m = '0;
    m[idx] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pfx_decode.sv
module pfx_decode
  import pfx_pkg::*;
(
  input  logic [7:0] instr_i,
  output grp_e       grp_o,
  output logic [2:0] sub_o,
  output logic [2:0] dst_o
);
  assign grp_o = grp_e'(instr_i[7:6]);
  assign sub_o = instr_i[5:3];
  assign dst_o = instr_i[2:0];
endmodule

// File: rtl/pfx_rotshift.sv
module pfx_rotshift
  import pfx_pkg::*;
(
  input  logic [2:0]   sub_i,
  input  logic [W-1:0] opnd_i,
  input  logic [7:0]   flags_i,
  output logic [W-1:0] res_o,
  output logic [7:0]   flags_o,
  output logic         cout_o
);
  rs_t r;
  always_comb begin
    r       = rs_eval(sub_i, opnd_i, flags_i[FC]);
    res_o   = r.val;
    cout_o  = r.cout;
    flags_o = flags_i;
    flags_o[FZ] = r.z_allowed & (r.val == '0);
    flags_o[FN] = 1'b0;
    flags_o[FH] = 1'b0;
    flags_o[FC] = r.cout;
  end
endmodule

// File: rtl/pfx_bitop.sv
module pfx_bitop
  import pfx_pkg::*;
(
  input  grp_e           grp_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [W-1:0]   opnd_i,
  input  logic [7:0]     flags_i,
  output logic [W-1:0]   res_o,
  output logic [7:0]     flags_o,
  output logic           we_o,
  output logic           tested_bit_o
);
  logic [W-1:0] mask;
  always_comb begin
    mask         = bit_mask(idx_i);
    tested_bit_o = |(opnd_i & mask);
    res_o        = opnd_i;
    flags_o      = flags_i;
    we_o         = 1'b1;
    case (grp_i)
      GRP_TEST: begin
        we_o        = 1'b0;
        flags_o[FZ] = ~tested_bit_o;
        flags_o[FN] = 1'b0;
        flags_o[FH] = 1'b1;
      end
      GRP_CLR: res_o = opnd_i & ~mask;
      GRP_SET: res_o = opnd_i | mask;
      default: res_o = opnd_i;
    endcase
  end
endmodule

// File: rtl/pfx_bitunit.sv
module pfx_bitunit
  import pfx_pkg::*;
(
  input  logic [7:0] instr_i,
  input  logic [7:0] opnd_i,
  input  logic [7:0] flags_i,
  output logic [7:0] result_o,
  output logic       wr_en_o,
  output logic [7:0] flags_o,
  output logic [2:0] dst_sel_o
);
  grp_e         grp;
  logic [2:0]   sub;
  logic [W-1:0] rs_res, bo_res;
  logic [7:0]   rs_flags, bo_flags;
  logic         rs_cout, bo_we, tested_bit;
  logic         is_shrot;

  pfx_decode u_dec (.instr_i(instr_i), .grp_o(grp), .sub_o(sub), .dst_o(dst_sel_o));

  pfx_rotshift u_rs (.sub_i(sub), .opnd_i(opnd_i), .flags_i(flags_i),
                     .res_o(rs_res), .flags_o(rs_flags), .cout_o(rs_cout));

  pfx_bitop u_bo (.grp_i(grp), .idx_i(sub[IDX_W-1:0]), .opnd_i(opnd_i), .flags_i(flags_i),
                  .res_o(bo_res), .flags_o(bo_flags), .we_o(bo_we),
                  .tested_bit_o(tested_bit));

  assign is_shrot = (grp == GRP_SHROT);
  assign result_o = is_shrot ? rs_res   : bo_res;
  assign flags_o  = is_shrot ? rs_flags : bo_flags;
  assign wr_en_o  = is_shrot ? 1'b1     : bo_we;
endmodule

// File: rtl/pfx_bitunit_chk.sv
module pfx_bitunit_chk (
  input logic [7:0] instr_i,
  input logic [7:0] opnd_i,
  input logic [7:0] flags_i,
  input logic [7:0] result_o,
  input logic       wr_en_o,
  input logic [7:0] flags_o,
  input logic [2:0] dst_sel_o,
  input logic       tested_bit,
  input logic       rs_cout
);
  always_comb begin
    a_r1_dst_field: assert (dst_sel_o == instr_i[2:0]) else $error("R1 dst_sel");
    a_r9_low_flags: assert (flags_o[3:0] == flags_i[3:0]) else $error("R9 low flags");
    if (instr_i[7:6] == 2'b01) begin
      a_r7_test_flags: assert (!wr_en_o && flags_o[7] == !tested_bit && flags_o[5]
                               && !flags_o[6] && flags_o[4] == flags_i[4])
        else $error("R7 bit test");
      a_r7_test_bit: assert (tested_bit == opnd_i[instr_i[5:3]]) else $error("R7 tested bit");
    end
    if (instr_i[7]) begin
      a_r8_flags_kept: assert (wr_en_o && flags_o == flags_i) else $error("R8 flags");
      a_r8_forced_bit: assert (result_o[instr_i[5:3]] == instr_i[6]) else $error("R8 bit");
    end
    if (instr_i[7:5] == 3'b000) begin
      a_r4_rot_clear: assert (flags_o[7:5] == 3'b000 && flags_o[4] == rs_cout)
        else $error("R4 rotate flags");
    end
  end
endmodule

bind pfx_bitunit pfx_bitunit_chk u_chk (
  .instr_i(instr_i), .opnd_i(opnd_i), .flags_i(flags_i), .result_o(result_o),
  .wr_en_o(wr_en_o), .flags_o(flags_o), .dst_sel_o(dst_sel_o),
  .tested_bit(tested_bit), .rs_cout(rs_cout)
);

// File: tb/sim_pfx_bitunit.sv
`timescale 1ns/1ps
module sim_pfx_bitunit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [7:0] instr, opnd, flg, res, fo;
  logic       we;
  logic [2:0] dst;
  int n_run = 0, n_fail = 0;
  int wd = 0;

  pfx_bitunit u0 (.instr_i(instr), .opnd_i(opnd), .flags_i(flg),
                  .result_o(res), .wr_en_o(we), .flags_o(fo), .dst_sel_o(dst));

  // instr, operand, flags in, expected result, expected flags, expected we
  typedef struct packed { logic [7:0] i, d, f, er, ef; logic ew; } vec_t;
  localparam vec_t VT [13] = '{
    '{8'h00, 8'h85, 8'h00, 8'h0B, 8'h10, 1'b1},   // R2 rotate left
    '{8'h08, 8'h01, 8'h00, 8'h80, 8'h10, 1'b1},   // R2 rotate right
    '{8'h10, 8'h80, 8'h10, 8'h01, 8'h10, 1'b1},   // R3 left through carry
    '{8'h18, 8'h01, 8'h00, 8'h00, 8'h10, 1'b1},   // R4 zero result, Z clear
    '{8'h20, 8'h80, 8'h00, 8'h00, 8'h90, 1'b1},   // R5 left shift to zero
    '{8'h28, 8'h81, 8'hF0, 8'hC0, 8'h10, 1'b1},   // R5 sign kept
    '{8'h38, 8'h01, 8'h00, 8'h00, 8'h90, 1'b1},   // R5 logical right
    '{8'h30, 8'h00, 8'h7F, 8'h00, 8'h8F, 1'b1},   // R6 swap zero
    '{8'h30, 8'hA5, 8'h00, 8'h5A, 8'h00, 1'b1},   // R6 swap
    '{8'h7C, 8'h7F, 8'h10, 8'h7F, 8'hB0, 1'b0},   // R7 test clear bit
    '{8'h46, 8'h01, 8'h40, 8'h01, 8'h20, 1'b0},   // R7 test set bit
    '{8'hC7, 8'h00, 8'hA5, 8'h01, 8'hA5, 1'b1},   // R8 set
    '{8'hBE, 8'hFF, 8'h5A, 8'h7F, 8'h5A, 1'b1}    // R8 clear
  };

  // Independent reference: bit-by-bit construction.
  function automatic logic [16:0] ref_model(input logic [7:0] i, input logic [7:0] d,
                                            input logic [7:0] f);
    logic [7:0] r, nf;
    logic c, w;
    int k;
    k  = int'(i[5:3]);
    r  = d; nf = f; w = 1'b1; c = f[4];
    if (i[7:6] == 2'b00) begin
      case (k)
        0: begin c = d[7]; r = (d << 1) | (d >> 7); end
        1: begin c = d[0]; r = (d >> 1) | (d << 7); end
        2: begin c = d[7]; r = (d << 1) | {7'd0, f[4]}; end
        3: begin c = d[0]; r = (d >> 1) | {f[4], 7'd0}; end
        4: begin c = d[7]; r = d << 1; end
        5: begin c = d[0]; r = (d >> 1) | (d & 8'h80); end
        6: begin c = 1'b0; r = (d << 4) | (d >> 4); end
        default: begin c = d[0]; r = d >> 1; end
      endcase
      nf = {(k >= 4) && (r == 8'd0), 1'b0, 1'b0, c, f[3:0]};
    end else if (i[7:6] == 2'b01) begin
      w  = 1'b0;
      nf = {~d[k], 1'b0, 1'b1, f[4], f[3:0]};
    end else if (i[7:6] == 2'b10) begin
      r = d & ~(8'd1 << k);
    end else begin
      r = d | (8'd1 << k);
    end
    return {r, nf, w};
  endfunction

  task automatic check(input string rq, input logic [16:0] exp);
    n_run++;
    if ({res, fo, we} !== exp || dst !== instr[2:0]) begin
      n_fail++;
      $display("FAIL %s instr=%h opnd=%h flags=%h got res=%h fl=%h we=%b dst=%0d exp res=%h fl=%h we=%b dst=%0d",
               rq, instr, opnd, flg, res, fo, we, dst, exp[16:9], exp[8:1], exp[0], instr[2:0]);
    end
  endtask

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  localparam logic [7:0] OPS [6] = '{8'h00, 8'h80, 8'h01, 8'hA5, 8'hFF, 8'h3C};

  initial begin
    instr = 8'h00; opnd = 8'h00; flg = 8'h00;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    #1;
    check("R4 idle-state", {8'h00, 8'h00, 1'b1});  // R4: rotate of zero keeps Z clear

    for (int v = 0; v < 13; v++) begin
      instr = VT[v].i; opnd = VT[v].d; flg = VT[v].f;
      #2;
      check("R2-R8 vector", {VT[v].er, VT[v].ef, VT[v].ew});
    end

    // Exhaustive sweep: R1 R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < 256; i++) begin
      for (int o = 0; o < 6; o++) begin
        for (int c = 0; c < 2; c++) begin
          instr = i[7:0]; opnd = OPS[o];
          flg = (c == 1) ? 8'h1A : 8'hE5;
          #2;
          check("R1 sweep", ref_model(instr, opnd, flg));
        end
      end
    end

    // R3 corner: right through set carry into zero operand
    instr = 8'h1B; opnd = 8'h00; flg = 8'h10; #2;
    check("R3 carry in", {8'h80, 8'h00, 1'b1});
    // R9 low flag nibble on bit test
    instr = 8'h40; opnd = 8'h00; flg = 8'h0F; #2;
    check("R9 low nibble", {8'h00, 8'hAF, 1'b0});

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule